// File: doc/BRIEF.md
# Raster Timing and Animation Counter Unit

This block produces the horizontal and vertical timing for a 320x224 raster. A free-running divider turns the master clock into a pixel clock enable, one pulse every `PIX_DIV` master clocks. A horizontal pixel counter and a vertical line counter run from that enable. The block decodes active-low sync and blank strobes from the two counters. It also gives a colour-output clear that covers every non-visible line, a one-clock line-start pulse, and the current pixel index. The interrupt logic downstream uses the pulse and the index to place its events.

The vertical counter is 9 bits wide and runs over the top 264 codes of its range, from 0x0F8 to 0x1FF. Its MSB is therefore low only during vertical sync. On each falling edge of vertical sync, an 8-bit reloadable frame divider counts down. Each time it underflows it advances a 3-bit animation counter. The animation counter replaces the low bits of a tile number, following a per-tile 2-bit mode and a global disable bit. A write-only control word sets the reload value and the disable bit. A read-only status word returns the line count and the animation phase.

Top module: `raster_anim_timer`

## Requirements
- R1: The pixel enable fires once every `PIX_DIV` clocks, and a line lasts 384 enables. `hcount_o` is 0 at the start of sync. `hsync_no` is low for pixels 0..27. `hblank_no` is low for 29 pixels after `hsync_no` rises, then high for 320 pixels (indices 57..376), then low for the 7 pixels before the next sync.
- R2: `vcount_o` advances by one in the clock where `hcount_o` returns to 0. It runs from 0x0F8 to 0x1FF, wraps from 0x1FF back to 0x0F8, and so gives 264 lines per frame.
- R3: `vsync_no` is low exactly while `vcount_o` is in 0x0F8..0x0FF. `vblank_no` is high exactly while `vcount_o` is in 0x110..0x1EF.
- R4: `color_clr_o` is high on all 40 lines outside 0x110..0x1EF and low on the active lines.
- R5: `line_start_o` is a pulse one clock wide, in the first clock in which `hsync_no` is high. At that clock `hcount_o` equals 28.
- R6: The 8-bit frame divider counts down on each falling edge of `vsync_no`. If it is 0 at that edge, it reloads instead, from `ctrl_wdata_i[15:8]` of the last control write. A control write never changes the divider directly, so a new reload value first acts at the next underflow.
- R7: The 3-bit animation counter increments at every divider underflow and wraps from 7 to 0. It keeps counting while animation is disabled.
- R8: Tile substitution by `tile_mode_i`. Mode 00 passes `tile_i` unchanged. Mode 01 replaces bits 1:0 with counter bits 1:0. Modes 10 and 11 replace bits 2:0 with counter bits 2:0.
- R9: While control bit 3 (written through `ctrl_wdata_i[3]`) is 1, `tile_o` equals `tile_i` for every mode.
- R10: `status_o` carries `vcount_o` on bits 15:7 and the animation counter on bits 2:0. Bits 6:3 are 0.
- R11: After reset, `hcount_o` is 0, `vcount_o` is 0x0F8, and the frame divider, animation counter, reload value and disable bit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word: 15:8 divider reload, 3 animation disable |
| tile_i | input | TILE_W | Tile number before substitution |
| tile_mode_i | input | 2 | Per-tile animation mode |
| pix_ce_o | output | 1 | Pixel clock enable |
| hcount_o | output | HCNT_W | Pixel index within the line, 0 at start of sync |
| hsync_no | output | 1 | Horizontal sync, active low |
| hblank_no | output | 1 | High during the 320 active pixels |
| vcount_o | output | 9 | Offset line counter |
| vsync_no | output | 1 | Vertical sync, active low |
| vblank_no | output | 1 | High during the 224 active lines |
| color_clr_o | output | 1 | Colour output clear on non-active lines |
| line_start_o | output | 1 | One-clock pulse at the rise of horizontal sync |
| status_o | output | 16 | Line count and animation phase |
| tile_o | output | TILE_W | Tile number after substitution |

## Verification
The bench goes after five corner cases.

- **Line geometry.** It measures every horizontal segment at the full 384-pixel line, with the pixel enable divided by four. A decode that is off by one would show as a 27- or 29-pixel sync, or a shifted active window.
- **Vertical wrap.** It follows a short-line instance through more than 25 frames and compares every line against an expected queue. A wrap to 0 or to 0x100 instead of 0x0F8 would break the count and the sync and blank decode at the frame seam.
- **Reload timing.** It changes the reload value in the middle of a divider period. A design that loaded the divider on the write would advance the animation counter one or more frames early.
- **Counter wrap and disable.** The animation counter is taken past 7, and the disable bit is held for several frames. A counter that saturated, or one that stopped while disabled, would go out of step with the model.
- **Substitution masks.** Every mode is applied to changing tile numbers, both enabled and disabled. This catches mode 11 treated as pass-through, or two bits and three bits swapped.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int V_SYNC_L = 8;
  localparam int V_TOP_L  = 16;
  localparam int V_ACT_L  = 224;
  localparam int V_BOT_L  = 16;
  localparam int V_TOTAL  = V_SYNC_L + V_TOP_L + V_ACT_L + V_BOT_L;
  localparam int V_CNT_W  = 9;
  localparam int V_SPAN   = 1 << V_CNT_W;

  localparam logic [V_CNT_W-1:0] V_FIRST     = V_CNT_W'(V_SPAN - V_TOTAL);
  localparam logic [V_CNT_W-1:0] V_LAST      = V_CNT_W'(V_SPAN - 1);
  localparam logic [V_CNT_W-1:0] V_SYNC_END  = V_CNT_W'(V_SPAN - V_TOTAL + V_SYNC_L);
  localparam logic [V_CNT_W-1:0] V_ACT_FIRST = V_CNT_W'(V_SPAN - V_TOTAL + V_SYNC_L + V_TOP_L);
  localparam logic [V_CNT_W-1:0] V_ACT_LAST  = V_CNT_W'(V_SPAN - V_TOTAL + V_SYNC_L + V_TOP_L + V_ACT_L - 1);

  localparam int ANIM_W       = 3;
  localparam int DIV_W        = 8;
  localparam int CTRL_W       = 16;
  localparam int CTRL_RLD_LSB = 8;
  localparam int CTRL_DIS_BIT = 3;
  localparam int STAT_PAD_W   = CTRL_W - V_CNT_W - ANIM_W;

  typedef enum logic [1:0] {
    ANIM_NONE  = 2'b00,
    ANIM_LOW2  = 2'b01,
    ANIM_LOW3  = 2'b10,
    ANIM_LOW3B = 2'b11
  } anim_mode_e;
endpackage

// File: rtl/raster_pix_enable.sv
module raster_pix_enable #(
  parameter int DIV = 4,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ce_o
);
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q == TOP) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign ce_o = (cnt_q == TOP);
endmodule

// File: rtl/raster_line_timer.sv
module raster_line_timer #(
  parameter int HSYNC_W  = 28,
  parameter int HLEFT_W  = 29,
  parameter int HACT_W   = 320,
  parameter int HRIGHT_W = 7,
  localparam int H_TOTAL = HSYNC_W + HLEFT_W + HACT_W + HRIGHT_W,
  localparam int HCNT_W  = $clog2(H_TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  output logic [HCNT_W-1:0] hcount_o,
  output logic              hsync_no,
  output logic              hblank_no,
  output logic              line_end_o,
  output logic              line_start_o
);
  localparam logic [HCNT_W-1:0] H_LAST     = HCNT_W'(H_TOTAL - 1);
  localparam logic [HCNT_W-1:0] H_SYNC_END = HCNT_W'(HSYNC_W);
  localparam logic [HCNT_W-1:0] H_ACT0     = HCNT_W'(HSYNC_W + HLEFT_W);
  localparam logic [HCNT_W-1:0] H_ACT_END  = HCNT_W'(HSYNC_W + HLEFT_W + HACT_W);

  logic [HCNT_W-1:0] h_q;
  logic              ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q  <= '0;
      ls_q <= 1'b0;
    end else begin
      ls_q <= ce_i && (h_q == H_SYNC_END - 1'b1);
      if (ce_i) h_q <= (h_q == H_LAST) ? '0 : h_q + 1'b1;
    end
  end

  assign hcount_o     = h_q;
  assign hsync_no     = (h_q >= H_SYNC_END);
  assign hblank_no    = (h_q >= H_ACT0) && (h_q < H_ACT_END);
  assign line_end_o   = ce_i && (h_q == H_LAST);
  assign line_start_o = ls_q;
endmodule

// File: rtl/raster_frame_timer.sv
module raster_frame_timer
  import raster_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_end_i,
  output logic [V_CNT_W-1:0] vcount_o,
  output logic               vsync_no,
  output logic               vblank_no,
  output logic               color_clr_o,
  output logic               frame_tick_o
);
  logic [V_CNT_W-1:0] v_q;
  logic               active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         v_q <= V_FIRST;
    else if (line_end_i) v_q <= (v_q == V_LAST) ? V_FIRST : v_q + 1'b1;
  end

  assign active       = (v_q >= V_ACT_FIRST) && (v_q <= V_ACT_LAST);
  assign vcount_o     = v_q;
  assign vsync_no     = (v_q >= V_SYNC_END);
  assign vblank_no    = active;
  assign color_clr_o  = !active;
  // sync falls when the count wraps back to its first code
  assign frame_tick_o = line_end_i && (v_q == V_LAST);
endmodule

// File: rtl/raster_anim_unit.sv
module raster_anim_unit
  import raster_pkg::*;
#(
  parameter int TILE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_tick_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [TILE_W-1:0] tile_i,
  input  logic [1:0]        tile_mode_i,
  output logic [ANIM_W-1:0] anim_o,
  output logic              anim_dis_o,
  output logic [TILE_W-1:0] tile_o
);
  logic [DIV_W-1:0]  reload_q, div_q;
  logic [ANIM_W-1:0] anim_q, mask;
  logic              dis_q, underflow;
  anim_mode_e        mode;
  logic              unused_ctrl_bits;

  assign unused_ctrl_bits = ^{ctrl_wdata_i[CTRL_RLD_LSB-1:CTRL_DIS_BIT+1],
                              ctrl_wdata_i[CTRL_DIS_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      dis_q    <= 1'b0;
    end else if (ctrl_we_i) begin
      reload_q <= ctrl_wdata_i[CTRL_RLD_LSB +: DIV_W];
      dis_q    <= ctrl_wdata_i[CTRL_DIS_BIT];
    end
  end

  assign underflow = frame_tick_i && (div_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      anim_q <= '0;
    end else if (frame_tick_i) begin
      if (underflow) begin
        div_q  <= reload_q;
        anim_q <= anim_q + 1'b1;
      end else begin
        div_q  <= div_q - 1'b1;
      end
    end
  end

  assign mode = anim_mode_e'(tile_mode_i);

  always_comb begin
    unique case (mode)
      ANIM_NONE: mask = '0;
      ANIM_LOW2: mask = ANIM_W'(3);
      default:   mask = '1;
    endcase
    if (dis_q) mask = '0;
  end

  for (genvar i = 0; i < TILE_W; i++) begin : g_tile
    if (i < ANIM_W) begin : g_sub
      assign tile_o[i] = mask[i] ? anim_q[i] : tile_i[i];
    end else begin : g_pass
      assign tile_o[i] = tile_i[i];
    end
  end

  assign anim_o     = anim_q;
  assign anim_dis_o = dis_q;
endmodule

// File: rtl/raster_anim_timer.sv
module raster_anim_timer
  import raster_pkg::*;
#(
  parameter int PIX_DIV  = 4,
  parameter int HSYNC_W  = 28,
  parameter int HLEFT_W  = 29,
  parameter int HACT_W   = 320,
  parameter int HRIGHT_W = 7,
  parameter int TILE_W   = 20,
  localparam int HCNT_W  = $clog2(HSYNC_W + HLEFT_W + HACT_W + HRIGHT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [15:0]       ctrl_wdata_i,
  input  logic [TILE_W-1:0] tile_i,
  input  logic [1:0]        tile_mode_i,
  output logic              pix_ce_o,
  output logic [HCNT_W-1:0] hcount_o,
  output logic              hsync_no,
  output logic              hblank_no,
  output logic [8:0]        vcount_o,
  output logic              vsync_no,
  output logic              vblank_no,
  output logic              color_clr_o,
  output logic              line_start_o,
  output logic [15:0]       status_o,
  output logic [TILE_W-1:0] tile_o
);
  logic              ce, line_end, frame_tick, anim_dis;
  logic [ANIM_W-1:0] anim;

  raster_pix_enable #(.DIV(PIX_DIV)) u_ce (
    .clk_i, .rst_ni, .ce_o(ce)
  );

  raster_line_timer #(
    .HSYNC_W(HSYNC_W), .HLEFT_W(HLEFT_W), .HACT_W(HACT_W), .HRIGHT_W(HRIGHT_W)
  ) u_line (
    .clk_i, .rst_ni, .ce_i(ce),
    .hcount_o, .hsync_no, .hblank_no,
    .line_end_o(line_end), .line_start_o
  );

  raster_frame_timer u_frame (
    .clk_i, .rst_ni, .line_end_i(line_end),
    .vcount_o, .vsync_no, .vblank_no, .color_clr_o,
    .frame_tick_o(frame_tick)
  );

  raster_anim_unit #(.TILE_W(TILE_W)) u_anim (
    .clk_i, .rst_ni, .frame_tick_i(frame_tick),
    .ctrl_we_i, .ctrl_wdata_i, .tile_i, .tile_mode_i,
    .anim_o(anim), .anim_dis_o(anim_dis), .tile_o
  );

  assign pix_ce_o = ce;
  assign status_o = {vcount_o, {STAT_PAD_W{1'b0}}, anim};
endmodule

// File: rtl/raster_anim_timer_chk.sv
module raster_anim_timer_chk #(
  parameter int HCNT_W = 9,
  parameter int TILE_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HCNT_W-1:0] hcount_o,
  input logic              hsync_no,
  input logic              hblank_no,
  input logic [8:0]        vcount_o,
  input logic              vsync_no,
  input logic              color_clr_o,
  input logic              line_start_o,
  input logic [2:0]        anim_i,
  input logic              anim_dis_i,
  input logic [TILE_W-1:0] tile_i,
  input logic [TILE_W-1:0] tile_o
);
  a_r2_vcount_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcount_o >= 9'h0F8);

  a_r2_vcount_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vcount_o) |-> (hcount_o == '0) &&
      ((vcount_o == $past(vcount_o) + 9'd1) ||
       (vcount_o == 9'h0F8 && $past(vcount_o) == 9'h1FF)));

  a_r5_line_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> $rose(hsync_no));

  a_r1_sync_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |-> !hblank_no);

  a_r4_clear_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_no |-> color_clr_o);

  a_r7_anim_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(anim_i) |-> $fell(vsync_no) && (anim_i == $past(anim_i) + 3'd1));

  a_r9_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    anim_dis_i |-> tile_o == tile_i);
endmodule

bind raster_anim_timer raster_anim_timer_chk #(.HCNT_W(HCNT_W), .TILE_W(TILE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hcount_o(hcount_o), .hsync_no(hsync_no),
  .hblank_no(hblank_no), .vcount_o(vcount_o), .vsync_no(vsync_no),
  .color_clr_o(color_clr_o), .line_start_o(line_start_o),
  .anim_i(status_o[2:0]), .anim_dis_i(anim_dis), .tile_i(tile_i), .tile_o(tile_o)
);

// File: tb/tb_raster_anim_timer.sv
module tb_raster_anim_timer;
  localparam int S_HSYNC = 2, S_HLEFT = 2, S_HACT = 4, S_HRIGHT = 1;
  localparam int S_HTOT  = S_HSYNC + S_HLEFT + S_HACT + S_HRIGHT;
  localparam int S_HCW   = $clog2(S_HTOT);
  localparam int F_HCW   = 9;
  localparam int TW      = 20;
  localparam int FRAMES  = 26;

  typedef struct packed { logic [8:0] v; logic [2:0] a; } item_t;

  logic clk, rst_n;
  int   total = 0, bad = 0;
  bit   done_s = 0, done_f = 0;
  item_t q[$];

  // short-line instance (scoreboarded over many frames)
  logic s_we; logic [15:0] s_wdata; logic [TW-1:0] s_tile, s_tile_o; logic [1:0] s_mode;
  logic s_ce, s_hs, s_hb, s_vs, s_vb, s_clr, s_ls;
  logic [S_HCW-1:0] s_hcount; logic [8:0] s_vcount; logic [15:0] s_status;

  // full-geometry instance (line measurements)
  logic f_ce, f_hs, f_hb, f_vs, f_vb, f_clr, f_ls;
  logic [F_HCW-1:0] f_hcount; logic [8:0] f_vcount; logic [15:0] f_status; logic [TW-1:0] f_tile_o;

  raster_anim_timer #(.PIX_DIV(1), .HSYNC_W(S_HSYNC), .HLEFT_W(S_HLEFT),
                      .HACT_W(S_HACT), .HRIGHT_W(S_HRIGHT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(s_we), .ctrl_wdata_i(s_wdata),
    .tile_i(s_tile), .tile_mode_i(s_mode), .pix_ce_o(s_ce), .hcount_o(s_hcount),
    .hsync_no(s_hs), .hblank_no(s_hb), .vcount_o(s_vcount), .vsync_no(s_vs),
    .vblank_no(s_vb), .color_clr_o(s_clr), .line_start_o(s_ls),
    .status_o(s_status), .tile_o(s_tile_o)
  );

  raster_anim_timer dut_full (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(1'b0), .ctrl_wdata_i(16'h0000),
    .tile_i({TW{1'b0}}), .tile_mode_i(2'b00), .pix_ce_o(f_ce), .hcount_o(f_hcount),
    .hsync_no(f_hs), .hblank_no(f_hb), .vcount_o(f_vcount), .vsync_no(f_vs),
    .vblank_no(f_vb), .color_clr_o(f_clr), .line_start_o(f_ls),
    .status_o(f_status), .tile_o(f_tile_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] exp_tile(logic [TW-1:0] t, logic [1:0] m,
                                             logic [2:0] a, bit dis);
    if (dis || m == 2'b00) return t;
    if (m == 2'b01) return {t[TW-1:2], a[1:0]};
    return {t[TW-1:3], a};
  endfunction

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    rst_n = 1'b0; s_we = 1'b0; s_wdata = '0; s_tile = '0; s_mode = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  end

  // full-geometry line measurements
  initial begin
    int n;
    @(posedge rst_n);
    chk("R11", "hcount at reset", f_hcount, 0);
    chk("R11", "vcount at reset", f_vcount, 9'h0F8);
    chk("R10", "status at reset", f_status, 16'h7C00);
    chk("R3", "vsync_n at reset", f_vs, 0);
    chk("R4", "colour clear at reset", f_clr, 1);
    n = 0;
    while (f_hs == 1'b0 && n < 5000) begin n++; @(negedge clk); end
    chk("R1", "hsync low clocks", n, 28 * 4);
    chk("R5", "line_start at hsync rise", f_ls, 1);
    chk("R5", "hcount at line start", f_hcount, 28);
    @(negedge clk);
    chk("R5", "line_start width", f_ls, 0);
    n = 1;
    while (f_hb == 1'b0 && n < 5000) begin n++; @(negedge clk); end
    chk("R1", "left border clocks", n, 29 * 4);
    chk("R1", "hcount at active start", f_hcount, 57);
    n = 0;
    while (f_hb == 1'b1 && n < 5000) begin n++; @(negedge clk); end
    chk("R1", "active clocks", n, 320 * 4);
    n = 0;
    while (f_hs == 1'b1 && n < 5000) begin n++; @(negedge clk); end
    chk("R1", "right border clocks", n, 7 * 4);
    chk("R2", "vcount after first line", f_vcount, 9'h0F9);
    chk("R1", "hcount wraps to sync start", f_hcount, 0);
    done_f = 1;
  end

  // driver: model pushes expected line items and applies writes
  initial begin
    int div, rel, anim, fr, ln, used;
    bit dis, nd;
    logic [7:0] nr;
    @(posedge rst_n);
    chk("R11", "short vcount at reset", s_vcount, 9'h0F8);
    chk("R10", "short status at reset", s_status, 16'h7C00);
    s_tile = 20'hFFFFF; s_mode = 2'b01;
    #1;
    chk("R11", "tile with counter at 0", s_tile_o, 20'hFFFFC);
    div = 0; rel = 0; anim = 0; dis = 0;
    for (int l = 0; l < FRAMES * 264; l++) begin
      fr = l / 264; ln = l % 264; used = 0;
      if (l > 0 && ln == 0) begin
        if (div == 0) begin div = rel; anim = (anim + 1) % 8; end
        else div--;
      end
      q.push_back(item_t'{v: 9'(9'h0F8 + ln), a: 3'(anim)});
      if (ln == 100 && (fr == 0 || fr == 4 || fr == 9 || fr == 13)) begin
        nr = (fr == 0) ? 8'd2 : 8'd0;
        nd = (fr == 9);
        s_wdata = {nr, 4'b0000, nd, 3'b000};
        s_we = 1'b1;
        @(negedge clk);
        s_we = 1'b0;
        used = 1; rel = nr; dis = nd;
      end
      if (ln == 150) begin
        s_mode = 2'(fr % 4);
        s_tile = 20'h5A5A5 + 20'(fr * 32'h1111);
        #1;
        chk(dis ? "R9" : "R8", "tile substitution", s_tile_o,
            exp_tile(s_tile, s_mode, 3'(anim), dis));
      end
      repeat (S_HTOT - used) @(negedge clk);
    end
    chk("R2", "expected queue drained", q.size(), 0);
    done_s = 1;
  end

  // monitor: compare at every line start of the short-line instance
  always @(negedge clk) begin
    item_t it;
    if (rst_n && s_ls) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 line start with empty queue: actual=1 expected=0");
      end else begin
        it = q.pop_front();
        chk("R2", "vcount", s_vcount, it.v);
        chk("R5", "hcount at line start", s_hcount, S_HSYNC);
        chk("R3", "vsync_n", s_vs, it.v >= 9'h100);
        chk("R3", "vblank_n", s_vb, it.v >= 9'h110 && it.v <= 9'h1EF);
        chk("R4", "colour clear", s_clr, !(it.v >= 9'h110 && it.v <= 9'h1EF));
        chk("R10", "status", s_status, {it.v, 4'b0000, it.a});
        chk("R6/R7", "animation counter", s_status[2:0], it.a);
      end
    end
  end

  initial begin
    fork
      wait (done_s && done_f);
      begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule